// File: doc/BRIEF.md
# Latched Upper-Address Memory Select Decoder

This block picks the memory target of each bus cycle in a 286-class machine with an ISA-style expansion bus. It takes the seven upper address bits A17..A23, from the CPU or from the slot's early copies of the same lines, and captures them in an address register. The register opens only while the CPU marks a valid address, or at any time while a DMA controller or bus master owns the bus and holds the address steady. All decoding works on the captured copy. A select therefore stays put for the whole cycle, however the raw address lines move.

From the captured bits the block drives active-low selects for two onboard RAM banks, the system BIOS ROM and an 8-bit option ROM window. It also drives the 16-bit memory indication and the two read and write strobes for the lower megabyte. Those two strobes are blocked when any of A20..A23 is set, so an 8-bit card that decodes only up to A19 cannot answer sixteen times across the 16 MB space. When the target is the 8-bit option ROM, the block holds the CPU ready line low for a set number of CPU clocks, which stretches the cycle. Every register runs on the CPU clock input, so the wait length scales with CPU speed.

Top module: `mem_select_decoder`

## Requirements
- R1: The address register loads `addr_hi` on a rising `clk` edge when `ale_gate` or `dma_mode` is high, and holds its value on every other edge. All outputs decode the registered value, not the live `addr_hi`.
- R2: `addr_hi` bit 0 is A17 and bit 6 is A23, so one code covers 128 KB. RAM bank 0 is codes 0x00..0x03 (0x000000..0x07FFFF). RAM bank 1 is code 0x04 (0x080000..0x09FFFF). The option ROM is code 0x06 (0x0C0000..0x0DFFFF). The BIOS ROM is code 0x07 (0x0E0000..0x0FFFFF) and also code 0x7F (0xFE0000..0xFFFFFF).
- R3: The four selects `ram0_sel_n`, `ram1_sel_n`, `opt_sel_n` and `bios_sel_n` are active low. A select goes low only while `memr_n` or `memw_n` is low, and at most one select is low at any time.
- R4: A registered code outside the map of R2 drives no select low and never pulls `cpu_ready` low.
- R5: `smemr_n` follows `memr_n` and `smemw_n` follows `memw_n` only when registered bits 6..3 (A20..A23) are all zero. Otherwise both stay high.
- R6: `memcs16_n` is low whenever the registered code falls in RAM bank 0, RAM bank 1 or the BIOS ROM, with or without a strobe. It is high for the option ROM and for unmapped codes.
- R7: During a strobe that hits the option ROM, `cpu_ready` goes low in the same cycle the strobe asserts. It stays low through the first WAIT_CLKS-1 rising edges and returns high after the WAIT_CLKS-th rising edge (default 4). Strobes to 16-bit targets never lower `cpu_ready`.
- R8: `cpu_ready` returns high as soon as both strobes are high. The next strobe starts the wait count again from zero.
- R9: While `rst_n` is low the register clears to code 0x00. With no strobe active after reset, all selects and both lower-megabyte strobes are high, `cpu_ready` is high and `memcs16_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; all state of the block runs on it |
| rst_n | input | 1 | Active-low reset, applied asynchronously |
| addr_hi | input | 7 | Upper address A17..A23 (bit 0 = A17) |
| ale_gate | input | 1 | High while the CPU drives a valid address |
| dma_mode | input | 1 | High while DMA or a bus master owns the bus |
| memr_n | input | 1 | Memory read command, active low |
| memw_n | input | 1 | Memory write command, active low |
| ram0_sel_n | output | 1 | RAM bank 0 select, active low |
| ram1_sel_n | output | 1 | RAM bank 1 select, active low |
| opt_sel_n | output | 1 | 8-bit option ROM select, active low |
| bios_sel_n | output | 1 | BIOS ROM select, active low |
| smemr_n | output | 1 | Memory read qualified to the lower megabyte |
| smemw_n | output | 1 | Memory write qualified to the lower megabyte |
| memcs16_n | output | 1 | 16-bit target indication, active low |
| cpu_ready | output | 1 | High lets the CPU finish the cycle |

## Verification
A wrong captured address shows at the next strobe as the wrong select, a changed `memcs16_n` level, or lower-megabyte strobes that pass or block wrongly. The bench therefore moves the live address after the register has closed and compares against the value that was captured. A faulty wait counter shows within WAIT_CLKS edges of the strobe as `cpu_ready` rising too early or too late. The bench samples ready on each edge of the window and again after an early strobe release, which also exposes a counter that does not clear between cycles.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int BLK_W       = 7;          // A17..A23
  localparam int LOW_MEG_MSB = 2;          // bits above this are A20..A23
  localparam logic [BLK_W-1:0] RAM0_LAST  = 7'h03;
  localparam logic [BLK_W-1:0] RAM1_BLK   = 7'h04;
  localparam logic [BLK_W-1:0] OPT_BLK    = 7'h06;
  localparam logic [BLK_W-1:0] BIOS_BLK   = 7'h07;
  localparam logic [BLK_W-1:0] BIOS_ALIAS = 7'h7F;
  localparam int NUM_SEL     = 4;

  typedef enum logic [2:0] {
    RG_NONE, RG_RAM0, RG_RAM1, RG_OPT, RG_BIOS
  } region_e;

  function automatic region_e classify(input logic [BLK_W-1:0] blk);
    if (blk <= RAM0_LAST)                        return RG_RAM0;
    else if (blk == RAM1_BLK)                    return RG_RAM1;
    else if (blk == OPT_BLK)                     return RG_OPT;
    else if (blk == BIOS_BLK || blk == BIOS_ALIAS) return RG_BIOS;
    else                                         return RG_NONE;
  endfunction

  function automatic logic is_wide(input region_e r);
    return (r == RG_RAM0) || (r == RG_RAM1) || (r == RG_BIOS);
  endfunction

  function automatic logic in_low_meg(input logic [BLK_W-1:0] blk);
    return blk[BLK_W-1:LOW_MEG_MSB+1] == '0;
  endfunction

  // one-hot select vector, bit order: ram0, ram1, opt, bios
  function automatic logic [NUM_SEL-1:0] sel_vec(input region_e r);
    logic [NUM_SEL-1:0] v;
    v = '0;
    case (r)
      RG_RAM0: v[0] = 1'b1;
      RG_RAM1: v[1] = 1'b1;
      RG_OPT:  v[2] = 1'b1;
      RG_BIOS: v[3] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/memdec_addr_reg.sv
module memdec_addr_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] addr_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q[i] <= 1'b0;
      else if (open_i) addr_q[i] <= addr_i[i];
    end
  end
endmodule

// File: rtl/memdec_region.sv
module memdec_region
  import memdec_pkg::*;
(
  input  logic [BLK_W-1:0]   blk_i,
  input  logic               cmd_i,
  output region_e            region_o,
  output logic [NUM_SEL-1:0] sel_o,
  output logic               wide_o,
  output logic               low_meg_o,
  output logic               narrow_o
);
  always_comb begin
    region_o  = classify(blk_i);
    wide_o    = is_wide(region_o);
    narrow_o  = (region_o == RG_OPT);
    low_meg_o = in_low_meg(blk_i);
    sel_o     = cmd_i ? sel_vec(region_o) : '0;
  end
endmodule

// File: rtl/memdec_ready.sv
module memdec_ready #(
  parameter int WAIT_CLKS = 4,
  localparam int CNT_W = $clog2(WAIT_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_i,
  input  logic             narrow_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CLKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_o <= '0;
    else if (!cmd_i)        cnt_o <= '0;
    else if (cnt_o < LIMIT) cnt_o <= cnt_o + 1'b1;
  end

  assign ready_o = !(cmd_i && narrow_i && (cnt_o < LIMIT));
endmodule

// File: rtl/mem_select_decoder.sv
module mem_select_decoder
  import memdec_pkg::*;
#(
  parameter int WAIT_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] addr_hi,
  input  logic             ale_gate,
  input  logic             dma_mode,
  input  logic             memr_n,
  input  logic             memw_n,
  output logic             ram0_sel_n,
  output logic             ram1_sel_n,
  output logic             opt_sel_n,
  output logic             bios_sel_n,
  output logic             smemr_n,
  output logic             smemw_n,
  output logic             memcs16_n,
  output logic             cpu_ready
);
  localparam int CNT_W = $clog2(WAIT_CLKS + 1);

  logic               latch_open;
  logic [BLK_W-1:0]   lat_addr;
  logic               cmd_active;
  region_e            region;
  logic [NUM_SEL-1:0] sel;
  logic               wide;
  logic               below_1m;
  logic               eight_bit;
  logic [CNT_W-1:0]   wait_cnt;

  assign latch_open = ale_gate | dma_mode;
  assign cmd_active = !memr_n || !memw_n;

  memdec_addr_reg #(.W(BLK_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .open_i(latch_open),
    .addr_i(addr_hi), .addr_q(lat_addr)
  );

  memdec_region u_dec (
    .blk_i(lat_addr), .cmd_i(cmd_active), .region_o(region),
    .sel_o(sel), .wide_o(wide), .low_meg_o(below_1m), .narrow_o(eight_bit)
  );

  memdec_ready #(.WAIT_CLKS(WAIT_CLKS)) u_rdy (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_active), .narrow_i(eight_bit),
    .cnt_o(wait_cnt), .ready_o(cpu_ready)
  );

  assign ram0_sel_n = !sel[0];
  assign ram1_sel_n = !sel[1];
  assign opt_sel_n  = !sel[2];
  assign bios_sel_n = !sel[3];
  assign smemr_n    = memr_n | !below_1m;
  assign smemw_n    = memw_n | !below_1m;
  assign memcs16_n  = !wide;
endmodule

// File: rtl/memdec_checker.sv
module memdec_checker #(
  parameter int BLK_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             memr_n,
  input logic             memw_n,
  input logic             latch_open,
  input logic [BLK_W-1:0] lat_addr,
  input logic             ram0_sel_n,
  input logic             ram1_sel_n,
  input logic             opt_sel_n,
  input logic             bios_sel_n,
  input logic             smemr_n,
  input logic             smemw_n,
  input logic             memcs16_n,
  input logic             cpu_ready
);
  logic [3:0] sel_low;
  assign sel_low = ~{ram0_sel_n, ram1_sel_n, opt_sel_n, bios_sel_n};

  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_open |=> (lat_addr == $past(lat_addr)));

  assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_low));

  assert_idle_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (memr_n && memw_n) |-> (sel_low == 4'b0000));

  assert_smemr_low_meg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smemr_n |-> (!memr_n && lat_addr[BLK_W-1:3] == '0));

  assert_smemw_low_meg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smemw_n |-> (!memw_n && lat_addr[BLK_W-1:3] == '0));

  assert_wide_not_opt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !memcs16_n |-> opt_sel_n);

  assert_wait_only_opt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> !opt_sel_n);

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (memr_n && memw_n) |-> cpu_ready);
endmodule

bind mem_select_decoder memdec_checker #(.BLK_W(memdec_pkg::BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .memr_n(memr_n), .memw_n(memw_n),
  .latch_open(latch_open), .lat_addr(lat_addr),
  .ram0_sel_n(ram0_sel_n), .ram1_sel_n(ram1_sel_n),
  .opt_sel_n(opt_sel_n), .bios_sel_n(bios_sel_n),
  .smemr_n(smemr_n), .smemw_n(smemw_n),
  .memcs16_n(memcs16_n), .cpu_ready(cpu_ready)
);

// File: tb/mem_select_decoder_test.sv
`timescale 1ns/1ps
module mem_select_decoder_test;
  localparam int WAIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] addr_hi = 7'h00;
  logic ale_gate = 1'b0, dma_mode = 1'b0, memr_n = 1'b1, memw_n = 1'b1;
  logic ram0_sel_n, ram1_sel_n, opt_sel_n, bios_sel_n;
  logic smemr_n, smemw_n, memcs16_n, cpu_ready;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mem_select_decoder #(.WAIT_CLKS(WAIT)) uut (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .ale_gate(ale_gate),
    .dma_mode(dma_mode), .memr_n(memr_n), .memw_n(memw_n),
    .ram0_sel_n(ram0_sel_n), .ram1_sel_n(ram1_sel_n), .opt_sel_n(opt_sel_n),
    .bios_sel_n(bios_sel_n), .smemr_n(smemr_n), .smemw_n(smemw_n),
    .memcs16_n(memcs16_n), .cpu_ready(cpu_ready)
  );

  function automatic logic [3:0] sels();
    return {ram0_sel_n, ram1_sel_n, opt_sel_n, bios_sel_n};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // open the register for one edge, through the CPU window or DMA
  task automatic load(input logic [6:0] a, input logic via_dma);
    @(negedge clk);
    addr_hi = a; ale_gate = !via_dma; dma_mode = via_dma;
    @(posedge clk);
    @(negedge clk);
    ale_gate = 1'b0; dma_mode = 1'b0;
  endtask

  task automatic strobe(input logic rd, input logic wr);
    @(negedge clk);
    memr_n = !rd; memw_n = !wr;
    #1;
  endtask

  task automatic t_reset();
    check("R9 selects after reset", sels(), 4'b1111);
    check("R9 smem after reset", {smemr_n, smemw_n}, 2'b11);
    check("R9 ready after reset", cpu_ready, 1);
    check("R9 memcs16 after reset", memcs16_n, 0);
  endtask

  task automatic t_map();
    load(7'h02, 1'b0);
    check("R6 ram0 wide no strobe", memcs16_n, 0);
    check("R3 no select without strobe", sels(), 4'b1111);
    strobe(1, 0);
    check("R2 ram0 code 0x02", sels(), 4'b0111);
    check("R5 smemr in low meg", smemr_n, 0);
    check("R5 smemw idle", smemw_n, 1);
    strobe(0, 0);
    load(7'h04, 1'b0);
    strobe(0, 1);
    check("R2 ram1 code 0x04", sels(), 4'b1011);
    check("R5 smemw in low meg", smemw_n, 0);
    check("R7 16-bit write no wait", cpu_ready, 1);
    strobe(0, 0);
    load(7'h07, 1'b0);
    strobe(1, 0);
    check("R2 bios code 0x07", sels(), 4'b1110);
    check("R6 bios wide", memcs16_n, 0);
    strobe(0, 0);
  endtask

  task automatic t_alias();
    load(7'h7F, 1'b0);
    strobe(1, 0);
    check("R2 bios alias 0x7F", sels(), 4'b1110);
    check("R5 smemr blocked above 1MB", smemr_n, 1);
    strobe(0, 0);
    load(7'h13, 1'b0);
    strobe(1, 1);
    check("R4 unmapped 0x13 no select", sels(), 4'b1111);
    check("R5 smem blocked for 0x13", {smemr_n, smemw_n}, 2'b11);
    check("R4 unmapped no wait", cpu_ready, 1);
    check("R6 unmapped not wide", memcs16_n, 1);
    strobe(0, 0);
    load(7'h05, 1'b0);
    strobe(1, 0);
    check("R4 unmapped 0x05 no select", sels(), 4'b1111);
    check("R5 smemr passes for 0x05", smemr_n, 0);
    strobe(0, 0);
  endtask

  task automatic t_hold();
    load(7'h07, 1'b0);
    @(negedge clk); addr_hi = 7'h00;
    @(negedge clk); addr_hi = 7'h06;
    strobe(1, 0);
    check("R1 closed register keeps bios", sels(), 4'b1110);
    strobe(0, 0);
    load(7'h04, 1'b1);
    strobe(1, 0);
    check("R1 dma opens register", sels(), 4'b1011);
    strobe(0, 0);
  endtask

  task automatic t_wait();
    load(7'h06, 1'b0);
    check("R6 option rom not wide", memcs16_n, 1);
    strobe(1, 0);
    check("R3 option select", sels(), 4'b1101);
    check("R7 ready low at strobe", cpu_ready, 0);
    for (int k = 1; k <= WAIT + 1; k++) begin
      @(negedge clk); #1;
      check(k < WAIT ? "R7 ready held" : "R7 ready released",
            cpu_ready, (k < WAIT) ? 0 : 1);
    end
    strobe(0, 0);
    strobe(0, 1);
    repeat (2) @(negedge clk);
    strobe(0, 0);
    check("R8 ready high on early release", cpu_ready, 1);
    strobe(1, 0);
    check("R8 restart low", cpu_ready, 0);
    repeat (WAIT - 1) @(negedge clk);
    #1;
    check("R8 count restarted from zero", cpu_ready, 0);
    @(negedge clk); #1;
    check("R8 release after full count", cpu_ready, 1);
    strobe(0, 0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_map();
    t_alias();
    t_hold();
    t_wait();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule